// File: doc/BRIEF.md
# Four-Bit Carry-Lookahead Adder Slice

This block is a purely combinational adder slice for a two-level carry-lookahead tree. It takes two operand nibbles and a carry-in. For each bit it forms a generate term (AND of the operand bits) and a propagate term (inclusive OR of the operand bits). From these it computes every internal carry as a flattened two-level sum of products of those terms and the carry-in. It returns the sum nibble together with a group propagate and a group generate.

The slice has no carry-out of its own. A higher lookahead level forms the carry into the next slice from the group pair as `grp_gen | (grp_prop & carry_in)`. The propagate term is an OR, so it cannot form the sum. Each sum bit therefore uses a separate XOR of the operand bits with its carry.

Top module: `clas_slice`

## Requirements
- R1: Per-bit generate is `op_a[i] & op_b[i]` and per-bit propagate is `op_a[i] | op_b[i]` (inclusive OR). Both are seen at the ports through `grp_gen` and `grp_prop`.
- R2: `grp_prop` is 1 exactly when every bit position has at least one operand bit set, i.e. the AND of all four OR-propagates.
- R3: `grp_gen` is `g3 | p3&g2 | p3&p2&g1 | p3&p2&p1&g0`. It is 1 exactly when `op_a + op_b` exceeds 15 with no carry-in.
- R4: `sum_out[i]` is `op_a[i] ^ op_b[i] ^ c[i]`, where `c[0]` is `carry_in`. For every input, `sum_out` equals the low four bits of `op_a + op_b + carry_in`.
- R5: The internal carries are flattened two-level terms: `c1 = g0|p0&c0`, `c2 = g1|p1&g0|p1&p0&c0`, `c3 = g2|p2&g1|p2&p1&g0|p2&p1&p0&c0`. When the carry-in is set and every propagate is 1, the carry travels through all four positions.
- R6: The slice has no carry-out port. `grp_gen | (grp_prop & carry_in)` equals bit 4 of `op_a + op_b + carry_in` for all 512 input combinations.
- R7: For `op_a`=0101, `op_b`=0011 and `carry_in`=0, the outputs are `sum_out`=1000, `grp_prop`=0 and `grp_gen`=0.
- R8: With all inputs at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 4 | Sum bits |
| grp_prop | output | 1 | Group propagate for the next lookahead level |
| grp_gen | output | 1 | Group generate for the next lookahead level |

## Verification
The sum and the group terms come from the same inputs in the same evaluation. One case needs care: the carry that leaves the slice is not on any port, so it exists only as the pair `grp_gen`/`grp_prop`. Vectors are chosen where both functions matter at once. Examples are 1010+0101, where the group propagates but generates nothing while the sum is all ones, and 1111+0000 with carry-in, where the sum wraps to zero and the only carry is `grp_prop & carry_in`. Every one of the 512 inputs is judged by rebuilding the five-bit result from `sum_out` and the group pair and comparing it with the arithmetic sum.

// File: rtl/clas_pkg.sv
package clas_pkg;
   localparam int unsigned CLAS_MAX_W = 8;

   typedef struct packed {
      logic gen;
      logic prop;
   } clas_grp_t;
endpackage

// File: rtl/clas_bitterms.sv
module clas_bitterms #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] gen,
   output logic [W-1:0] prop,
   output logic [W-1:0] half
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen[i]  = a[i] & b[i];
      assign prop[i] = a[i] | b[i];
      assign half[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/clas_carry_net.sv
module clas_carry_net #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] gen,
   input  logic [W-1:0] prop,
   input  logic         cin,
   output logic [W-1:0] carry
);
   assign carry[0] = cin;

   for (genvar i = 1; i < W; i++) begin : g_carry
      always_comb begin
         logic acc;
         logic term;
         acc = 1'b0;
         for (int j = 0; j < i; j++) begin
            term = gen[j];
            for (int k = j + 1; k < i; k++) term = term & prop[k];
            acc = acc | term;
         end
         term = cin;
         for (int k = 0; k < i; k++) term = term & prop[k];
         carry[i] = acc | term;
      end
   end
endmodule

// File: rtl/clas_group.sv
module clas_group
   import clas_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] gen,
   input  logic [W-1:0] prop,
   output clas_grp_t    grp
);
   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < W; j++) begin
         term = gen[j];
         for (int k = j + 1; k < W; k++) term = term & prop[k];
         acc = acc | term;
      end
      grp.gen  = acc;
      grp.prop = &prop;
   end
endmodule

// File: rtl/clas_slice.sv
module clas_slice
   import clas_pkg::*;
#(
   parameter int unsigned SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] op_a,
   input  logic [SLICE_W-1:0] op_b,
   input  logic               carry_in,
   output logic [SLICE_W-1:0] sum_out,
   output logic               grp_prop,
   output logic               grp_gen
);
   if (SLICE_W < 1 || SLICE_W > CLAS_MAX_W) begin : g_bad_width
      $error("clas_slice: SLICE_W out of range");
   end

   logic [SLICE_W-1:0] bit_gen;
   logic [SLICE_W-1:0] bit_prop;
   logic [SLICE_W-1:0] bit_half;
   logic [SLICE_W-1:0] bit_carry;
   clas_grp_t          grp;

   clas_bitterms #(.W(SLICE_W)) u_terms (
      .a    (op_a),
      .b    (op_b),
      .gen  (bit_gen),
      .prop (bit_prop),
      .half (bit_half)
   );

   clas_carry_net #(.W(SLICE_W)) u_carry (
      .gen   (bit_gen),
      .prop  (bit_prop),
      .cin   (carry_in),
      .carry (bit_carry)
   );

   clas_group #(.W(SLICE_W)) u_group (
      .gen  (bit_gen),
      .prop (bit_prop),
      .grp  (grp)
   );

   assign sum_out  = bit_half ^ bit_carry;
   assign grp_prop = grp.prop;
   assign grp_gen  = grp.gen;
endmodule

// File: rtl/clas_slice_chk.sv
module clas_slice_chk #(
   parameter int unsigned SLICE_W = 4
) (
   input logic [SLICE_W-1:0] op_a,
   input logic [SLICE_W-1:0] op_b,
   input logic               carry_in,
   input logic [SLICE_W-1:0] sum_out,
   input logic               grp_prop,
   input logic               grp_gen
);
   logic [SLICE_W:0] total;
   logic [SLICE_W:0] nocin;
   assign total = {1'b0, op_a} + {1'b0, op_b} + {{SLICE_W{1'b0}}, carry_in};
   assign nocin = {1'b0, op_a} + {1'b0, op_b};

   always_comb begin
      assert_sum_low_R4: assert (sum_out == total[SLICE_W-1:0]);
      assert_group_carry_R6: assert ((grp_gen | (grp_prop & carry_in)) == total[SLICE_W]);
      assert_prop_cover_R2: assert (grp_prop == &(op_a | op_b));
      assert_gen_overflow_R3: assert (grp_gen == nocin[SLICE_W]);
      assert_full_chain_R5: assert (!(carry_in && grp_prop) || total[SLICE_W]);
   end
endmodule

bind clas_slice clas_slice_chk #(.SLICE_W(SLICE_W)) u_chk (
   .op_a     (op_a),
   .op_b     (op_b),
   .carry_in (carry_in),
   .sum_out  (sum_out),
   .grp_prop (grp_prop),
   .grp_gen  (grp_gen)
);

// File: tb/sim_clas_slice.sv
module sim_clas_slice;
   localparam int unsigned W = 4;
   localparam int unsigned NVEC = 8;
   // {a, b, c0, sum, P, G}
   localparam logic [14:0] VEC [NVEC] = '{
      15'b0101_0011_0_1000_0_0,
      15'b1111_0000_1_0000_1_0,
      15'b1111_0001_0_0000_1_1,
      15'b0000_0000_1_0001_0_0,
      15'b1000_1000_0_0000_0_1,
      15'b1010_0101_0_1111_1_0,
      15'b1111_1111_1_1111_1_1,
      15'b0011_0001_0_0100_0_0
   };

   logic         clk = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum_out;
   logic         grp_prop;
   logic         grp_gen;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clas_slice #(.SLICE_W(W)) u0 (
      .op_a     (op_a),
      .op_b     (op_b),
      .carry_in (carry_in),
      .sum_out  (sum_out),
      .grp_prop (grp_prop),
      .grp_gen  (grp_gen)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s a=%b b=%b c0=%b actual=%0d expected=%0d",
                  req, op_a, op_b, carry_in, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
      @(negedge clk);
      op_a = a; op_b = b; carry_in = c;
      #2;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R8: all-zero inputs give all-zero outputs
      apply('0, '0, 1'b0);
      chk("R8 sum", int'(sum_out), 0);
      chk("R8 prop", int'(grp_prop), 0);
      chk("R8 gen", int'(grp_gen), 0);

      // Table walk (R1, R2, R3, R4, R7)
      for (int v = 0; v < NVEC; v++) begin
         apply(VEC[v][14:11], VEC[v][10:7], VEC[v][6]);
         chk("R4 table sum", int'(sum_out), int'(VEC[v][5:2]));
         chk("R2 table prop", int'(grp_prop), int'(VEC[v][1]));
         chk("R3 table gen", int'(grp_gen), int'(VEC[v][0]));
      end

      // R7: worked example
      apply(4'b0101, 4'b0011, 1'b0);
      chk("R7 sum", int'(sum_out), 8);
      chk("R7 prop", int'(grp_prop), 0);
      chk("R7 gen", int'(grp_gen), 0);

      // R1: propagate is OR, not XOR (1+1 in every bit sets P)
      apply(4'b1111, 4'b1111, 1'b0);
      chk("R1 or-prop", int'(grp_prop), 1);
      chk("R1 and-gen", int'(grp_gen), 1);

      // R5: carry-in runs through all positions
      apply(4'b1010, 4'b0101, 1'b1);
      chk("R5 chain sum", int'(sum_out), 0);
      chk("R5 chain carry", int'(grp_gen | (grp_prop & carry_in)), 1);

      // Exhaustive sweep (R4, R6, R2, R3)
      for (int c = 0; c < 2; c++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               int total;
               apply(a[W-1:0], b[W-1:0], c[0]);
               total = a + b + c;
               chk("R4 sweep sum", int'(sum_out), total % 16);
               chk("R6 sweep carry", int'(grp_gen | (grp_prop & carry_in)), total / 16);
               chk("R2 sweep prop", int'(grp_prop), int'(&(a[W-1:0] | b[W-1:0])));
               chk("R3 sweep gen", int'(grp_gen), int'((a + b) > 15));
            end
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule